// File: doc/BRIEF.md
# SPI Message Transfer Sequencer

This block drives a byte-level SPI engine so that software does not have to handle each byte. A caller loads a small table of transfer descriptors and a transmit buffer, then queues messages. A message names a run of consecutive descriptors. Each descriptor gives a byte count, whether transmit data exists, whether received data is kept, where those bytes live in the local buffers, whether chip select is released after it, and how many microseconds to pause once its last byte is done.

The sequencer pulls one message at a time from a FIFO. It hands the engine the message's mode and speed settings and raises chip select. It then feeds bytes one by one and stores the returned bytes. A write collision makes it resend the same byte. A mode fault aborts the message. Between transfers it holds the descriptor's delay. Each message ends with a one-cycle completion pulse that carries an error flag and the number of bytes in fully completed transfers. Engine events that arrive while nothing is expected raise a one-cycle spurious flag.

Top module: `spi_msg_seq`

## Requirements
- R1: Messages run one at a time in push order. While the queue is empty the sequencer stays idle with chip select low and no byte request. A push while `msgFull` is high is discarded.
- R2: When a message starts, `engCfgLoad` pulses once with that message's `engMode` and `engSpeed`. `csActive` is high before and during every `engTxValid`.
- R3: With transmit enabled, a transfer sends the transmit buffer bytes from its transmit base upward, one per byte slot. With transmit disabled it sends 0x00 for every byte.
- R4: With receive enabled, the byte returned for slot n is written to receive buffer address base+n. With receive disabled the receive buffer is left unchanged.
- R5: On `engWcol` during a byte, the same byte is requested again. The byte position and the remaining count do not advance.
- R6: On `engModf` during a byte (with no collision in the same cycle), chip select drops and `msgDone` pulses with `msgErr`=1. `msgActualLen` counts only the transfers that finished before the fault, and the sequencer returns to idle.
- R7: After the last byte of a transfer, the next byte request or the message completion comes no earlier than delay×(CLK_HZ/1e6) cycles later. A delay of 0 adds no wait.
- R8: Between two transfers of one message, chip select goes low for one cycle only when the finished transfer's release flag is set. Otherwise it stays high.
- R9: After the final transfer's delay, chip select drops and `msgDone` pulses with `msgErr`=0 and `msgActualLen` equal to the sum of all transfer lengths.
- R10: An engine event (`engDone`, `engWcol` or `engModf`) in the idle state gives a one-cycle `spurious` pulse and has no other effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| msgPush | input | 1 | Enqueue a message |
| msgFirst | input | XI_W | Index of the message's first descriptor |
| msgNum | input | XC_W | Number of transfers in the message (at least 1) |
| msgMode | input | 3 | Engine mode bits for the message |
| msgSpeed | input | 8 | Engine divider setting for the message |
| msgFull | output | 1 | Message queue full |
| xdWe | input | 1 | Descriptor write enable |
| xdAddr | input | XI_W | Descriptor index |
| xdLen | input | LEN_W | Byte count (at least 1) |
| xdTxEn | input | 1 | Transmit data present |
| xdRxEn | input | 1 | Keep received bytes |
| xdCsDrop | input | 1 | Release chip select after this transfer |
| xdDelayUs | input | DLY_W | Pause after the last byte, in microseconds |
| xdTxBase | input | BUF_W | Transmit buffer start address |
| xdRxBase | input | BUF_W | Receive buffer start address |
| txWe | input | 1 | Transmit buffer write enable |
| txAddr | input | BUF_W | Transmit buffer write address |
| txData | input | 8 | Transmit buffer write data |
| rxAddr | input | BUF_W | Receive buffer read address |
| rxData | output | 8 | Receive buffer read data (combinational) |
| engCfgLoad | output | 1 | Load mode and speed into the engine |
| engMode | output | 3 | Mode to load |
| engSpeed | output | 8 | Speed to load |
| engTxValid | output | 1 | Byte request to the engine |
| engTxByte | output | 8 | Byte to shift out |
| engDone | input | 1 | Byte finished, `engRxByte` valid |
| engRxByte | input | 8 | Received byte |
| engWcol | input | 1 | Write collision on the current byte |
| engModf | input | 1 | Mode fault |
| csActive | output | 1 | Chip select asserted (active high) |
| msgDone | output | 1 | One-cycle message completion pulse |
| msgErr | output | 1 | Completion status, 1 = mode fault |
| msgActualLen | output | ACT_W | Bytes in completed transfers, valid with `msgDone` |
| spurious | output | 1 | Engine event while idle or waiting |

## Verification
The properties assume the engine answers each byte request with exactly one event, never before the request and never during the cycle of the request itself. They also assume every descriptor has a non-zero length and every message at least one transfer. The bench models the engine as a synchronous responder. It answers each request after a fixed latency with done, collision or fault chosen by byte index. It loads only non-zero lengths and counts. The only events it injects outside a transfer are single-cycle pokes while the sequencer is idle.

// File: rtl/seq_pkg.sv
package seq_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_LOAD,
    S_SEND,
    S_XFER,
    S_WAIT
  } seqState_t;

  // strobes from control into the datapath
  typedef struct packed {
    logic popMsg;
    logic loadXfer;
    logic acceptByte;
    logic startWait;
    logic finishXfer;
  } seqStrobe_t;

endpackage

// File: rtl/seq_msg_fifo.sv
module seq_msg_fifo #(
  parameter int DEPTH = 4,
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic [WIDTH-1:0] pushData,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic             empty,
  output logic             full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] count;
  logic doPush, doPop;

  assign empty  = (count == '0);
  assign full   = (count == CNT_W'(DEPTH));
  assign doPush = push && !full;
  assign doPop  = pop && !empty;
  assign head   = mem[rdPtr];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= (wrPtr == PTR_W'(DEPTH - 1)) ? '0 : wrPtr + 1'b1;
      if (doPop)  rdPtr <= (rdPtr == PTR_W'(DEPTH - 1)) ? '0 : rdPtr + 1'b1;
      count <= count + CNT_W'(doPush) - CNT_W'(doPop);
    end
  end

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= pushData;
  end

  // R1
  full_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (push && full && !pop) |=> (count == $past(count)));

endmodule

// File: rtl/seq_datapath.sv
module seq_datapath
  import seq_pkg::*;
#(
  parameter int CLK_HZ = 8_000_000,
  parameter int NXFER  = 8,
  parameter int BUF_W  = 6,
  parameter int LEN_W  = 7,
  parameter int DLY_W  = 8,
  parameter int XI_W   = 3,
  parameter int XC_W   = 4,
  parameter int ACT_W  = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqStrobe_t       st,
  input  logic             inWait,
  input  logic [XI_W-1:0]  headFirst,
  input  logic [XC_W-1:0]  headNum,
  input  logic             xdWe,
  input  logic [XI_W-1:0]  xdAddr,
  input  logic [LEN_W-1:0] xdLen,
  input  logic             xdTxEn,
  input  logic             xdRxEn,
  input  logic             xdCsDrop,
  input  logic [DLY_W-1:0] xdDelayUs,
  input  logic [BUF_W-1:0] xdTxBase,
  input  logic [BUF_W-1:0] xdRxBase,
  input  logic             txWe,
  input  logic [BUF_W-1:0] txAddr,
  input  logic [7:0]       txData,
  input  logic [BUF_W-1:0] rxAddr,
  output logic [7:0]       rxData,
  input  logic [7:0]       engRxByte,
  output logic [7:0]       txByte,
  output logic             lastByte,
  output logic             lastXfer,
  output logic             csDrop,
  output logic             waitOver,
  output logic [ACT_W-1:0] actualLen
);
  localparam int BUF_D = 1 << BUF_W;
  localparam int TICKS = (CLK_HZ / 1_000_000 < 1) ? 1 : CLK_HZ / 1_000_000;
  localparam int PRE_W = (TICKS > 1) ? $clog2(TICKS) : 1;

  // descriptor table
  logic [LEN_W-1:0] dLen    [NXFER];
  logic             dTxEn   [NXFER];
  logic             dRxEn   [NXFER];
  logic             dCsDrop [NXFER];
  logic [DLY_W-1:0] dDelay  [NXFER];
  logic [BUF_W-1:0] dTxBase [NXFER];
  logic [BUF_W-1:0] dRxBase [NXFER];

  logic [7:0] txMem [BUF_D];
  logic [7:0] rxMem [BUF_D];

  // current transfer state
  logic [XI_W-1:0]  xferIdx;
  logic [XC_W-1:0]  xfersLeft;
  logic [LEN_W-1:0] lenLeft, curLen;
  logic [BUF_W-1:0] txPtr, rxPtr;
  logic             hasTx, hasRx, csDropR;
  logic [DLY_W-1:0] curDelay, dlyLeft;
  logic [ACT_W-1:0] actual;
  logic             usTick;

  always_ff @(posedge clk) begin
    if (xdWe) begin
      dLen[xdAddr]    <= xdLen;
      dTxEn[xdAddr]   <= xdTxEn;
      dRxEn[xdAddr]   <= xdRxEn;
      dCsDrop[xdAddr] <= xdCsDrop;
      dDelay[xdAddr]  <= xdDelayUs;
      dTxBase[xdAddr] <= xdTxBase;
      dRxBase[xdAddr] <= xdRxBase;
    end
    if (txWe) txMem[txAddr] <= txData;
    if (st.acceptByte && hasRx) rxMem[rxPtr] <= engRxByte;
  end

  assign rxData = rxMem[rxAddr];
  assign txByte = hasTx ? txMem[txPtr] : 8'h00;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      xferIdx   <= '0;
      xfersLeft <= '0;
      lenLeft   <= '0;
      curLen    <= '0;
      txPtr     <= '0;
      rxPtr     <= '0;
      hasTx     <= 1'b0;
      hasRx     <= 1'b0;
      csDropR   <= 1'b0;
      curDelay  <= '0;
      actual    <= '0;
    end else begin
      if (st.popMsg) begin
        xferIdx   <= headFirst;
        xfersLeft <= headNum;
        actual    <= '0;
      end
      if (st.loadXfer) begin
        lenLeft  <= dLen[xferIdx];
        curLen   <= dLen[xferIdx];
        txPtr    <= dTxBase[xferIdx];
        rxPtr    <= dRxBase[xferIdx];
        hasTx    <= dTxEn[xferIdx];
        hasRx    <= dRxEn[xferIdx];
        csDropR  <= dCsDrop[xferIdx];
        curDelay <= dDelay[xferIdx];
      end
      if (st.acceptByte) begin
        lenLeft <= lenLeft - 1'b1;
        txPtr   <= txPtr + 1'b1;
        rxPtr   <= rxPtr + 1'b1;
      end
      if (st.finishXfer) begin
        actual    <= actual + ACT_W'(curLen);
        xferIdx   <= xferIdx + 1'b1;
        xfersLeft <= xfersLeft - 1'b1;
      end
    end
  end

  // microsecond tick: a prescaler only when more than one clock per microsecond
  if (TICKS > 1) begin : g_pre
    logic [PRE_W-1:0] preCnt;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                       preCnt <= '0;
      else if (st.startWait || !inWait) preCnt <= '0;
      else if (preCnt == PRE_W'(TICKS - 1)) preCnt <= '0;
      else                             preCnt <= preCnt + 1'b1;
    end
    assign usTick = inWait && (preCnt == PRE_W'(TICKS - 1));
  end else begin : g_nopre
    assign usTick = inWait;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                        dlyLeft <= '0;
    else if (st.startWait)            dlyLeft <= curDelay;
    else if (usTick && dlyLeft != '0) dlyLeft <= dlyLeft - 1'b1;
  end

  assign lastByte  = (lenLeft == LEN_W'(1));
  assign lastXfer  = (xfersLeft == XC_W'(1));
  assign csDrop    = csDropR;
  assign waitOver  = (dlyLeft == '0);
  assign actualLen = actual;

endmodule

// File: rtl/seq_control.sv
module seq_control
  import seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       qEmpty,
  input  logic [2:0] qMode,
  input  logic [7:0] qSpeed,
  input  logic       lastByte,
  input  logic       lastXfer,
  input  logic       csDrop,
  input  logic       waitOver,
  input  logic [7:0] txByte,
  input  logic       engDone,
  input  logic       engWcol,
  input  logic       engModf,
  output seqStrobe_t st,
  output logic       popQ,
  output logic       inWait,
  output logic       engCfgLoad,
  output logic [2:0] engMode,
  output logic [7:0] engSpeed,
  output logic       engTxValid,
  output logic       csActive,
  output logic       msgDone,
  output logic       msgErr,
  output logic       spurious
);
  seqState_t state, nxt;
  logic anyEvt, faultHit;

  assign anyEvt   = engDone | engWcol | engModf;
  assign faultHit = (state == S_XFER) && !engWcol && engModf;

  always_comb begin
    nxt = state;
    st  = '0;
    case (state)
      S_IDLE: if (!qEmpty) begin
        st.popMsg = 1'b1;
        nxt = S_LOAD;
      end
      S_LOAD: begin
        st.loadXfer = 1'b1;
        nxt = S_SEND;
      end
      S_SEND: nxt = S_XFER;
      S_XFER: begin
        if (engWcol) nxt = S_SEND;
        else if (engModf) nxt = S_IDLE;
        else if (engDone) begin
          st.acceptByte = 1'b1;
          if (lastByte) begin
            st.startWait = 1'b1;
            nxt = S_WAIT;
          end else begin
            nxt = S_SEND;
          end
        end
      end
      S_WAIT: if (waitOver) begin
        st.finishXfer = 1'b1;
        nxt = lastXfer ? S_IDLE : S_LOAD;
      end
      default: nxt = S_IDLE;
    endcase
  end

  assign popQ       = st.popMsg;
  assign inWait     = (state == S_WAIT);
  assign engTxValid = (state == S_SEND);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= S_IDLE;
      engCfgLoad <= 1'b0;
      engMode    <= '0;
      engSpeed   <= '0;
      csActive   <= 1'b0;
      msgDone    <= 1'b0;
      msgErr     <= 1'b0;
      spurious   <= 1'b0;
    end else begin
      state      <= nxt;
      engCfgLoad <= st.popMsg;
      msgDone    <= 1'b0;
      spurious   <= ((state == S_IDLE) || (state == S_WAIT)) && anyEvt;
      if (st.popMsg) begin
        engMode  <= qMode;
        engSpeed <= qSpeed;
      end
      if (st.loadXfer) csActive <= 1'b1;
      if (faultHit) begin
        csActive <= 1'b0;
        msgDone  <= 1'b1;
        msgErr   <= 1'b1;
      end
      if (st.finishXfer) begin
        if (lastXfer) begin
          csActive <= 1'b0;
          msgDone  <= 1'b1;
          msgErr   <= 1'b0;
        end else if (csDrop) begin
          csActive <= 1'b0;
        end
      end
    end
  end

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_IDLE) |-> (!csActive && !engTxValid));

  // R2
  tx_cs_chk: assert property (@(posedge clk) disable iff (!rstN)
    engTxValid |-> csActive);

  // R5
  wcol_resend_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_XFER && engWcol) |=> (engTxValid && txByte == $past(txByte)));

  // R6
  modf_abort_chk: assert property (@(posedge clk) disable iff (!rstN)
    faultHit |=> (msgDone && msgErr && !csActive));

  // R7
  wait_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_WAIT && !waitOver) |=> (state == S_WAIT && !engTxValid));

  // R9
  done_ok_chk: assert property (@(posedge clk) disable iff (!rstN)
    (st.finishXfer && lastXfer) |=> (msgDone && !msgErr && !csActive));

endmodule

// File: rtl/spi_msg_seq.sv
module spi_msg_seq
  import seq_pkg::*;
#(
  parameter int CLK_HZ = 8_000_000,
  parameter int QDEPTH = 4,
  parameter int NXFER  = 8,
  parameter int BUF_W  = 6,
  parameter int LEN_W  = 7,
  parameter int DLY_W  = 8,
  parameter int XI_W   = $clog2(NXFER),
  parameter int XC_W   = $clog2(NXFER + 1),
  parameter int ACT_W  = LEN_W + XI_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             msgPush,
  input  logic [XI_W-1:0]  msgFirst,
  input  logic [XC_W-1:0]  msgNum,
  input  logic [2:0]       msgMode,
  input  logic [7:0]       msgSpeed,
  output logic             msgFull,
  input  logic             xdWe,
  input  logic [XI_W-1:0]  xdAddr,
  input  logic [LEN_W-1:0] xdLen,
  input  logic             xdTxEn,
  input  logic             xdRxEn,
  input  logic             xdCsDrop,
  input  logic [DLY_W-1:0] xdDelayUs,
  input  logic [BUF_W-1:0] xdTxBase,
  input  logic [BUF_W-1:0] xdRxBase,
  input  logic             txWe,
  input  logic [BUF_W-1:0] txAddr,
  input  logic [7:0]       txData,
  input  logic [BUF_W-1:0] rxAddr,
  output logic [7:0]       rxData,
  output logic             engCfgLoad,
  output logic [2:0]       engMode,
  output logic [7:0]       engSpeed,
  output logic             engTxValid,
  output logic [7:0]       engTxByte,
  input  logic             engDone,
  input  logic [7:0]       engRxByte,
  input  logic             engWcol,
  input  logic             engModf,
  output logic             csActive,
  output logic             msgDone,
  output logic             msgErr,
  output logic [ACT_W-1:0] msgActualLen,
  output logic             spurious
);
  localparam int QW = XI_W + XC_W + 3 + 8;

  seqStrobe_t     st;
  logic           popQ, qEmpty, inWait;
  logic [QW-1:0]  qHead;
  logic           lastByte, lastXfer, csDrop, waitOver;

  seq_msg_fifo #(.DEPTH(QDEPTH), .WIDTH(QW)) u_fifo (
    .clk      (clk),
    .rstN     (rstN),
    .push     (msgPush),
    .pushData ({msgFirst, msgNum, msgMode, msgSpeed}),
    .pop      (popQ),
    .head     (qHead),
    .empty    (qEmpty),
    .full     (msgFull)
  );

  seq_datapath #(
    .CLK_HZ(CLK_HZ), .NXFER(NXFER), .BUF_W(BUF_W), .LEN_W(LEN_W),
    .DLY_W(DLY_W), .XI_W(XI_W), .XC_W(XC_W), .ACT_W(ACT_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .st        (st),
    .inWait    (inWait),
    .headFirst (qHead[QW-1 -: XI_W]),
    .headNum   (qHead[QW-XI_W-1 -: XC_W]),
    .xdWe      (xdWe),
    .xdAddr    (xdAddr),
    .xdLen     (xdLen),
    .xdTxEn    (xdTxEn),
    .xdRxEn    (xdRxEn),
    .xdCsDrop  (xdCsDrop),
    .xdDelayUs (xdDelayUs),
    .xdTxBase  (xdTxBase),
    .xdRxBase  (xdRxBase),
    .txWe      (txWe),
    .txAddr    (txAddr),
    .txData    (txData),
    .rxAddr    (rxAddr),
    .rxData    (rxData),
    .engRxByte (engRxByte),
    .txByte    (engTxByte),
    .lastByte  (lastByte),
    .lastXfer  (lastXfer),
    .csDrop    (csDrop),
    .waitOver  (waitOver),
    .actualLen (msgActualLen)
  );

  seq_control u_ctl (
    .clk        (clk),
    .rstN       (rstN),
    .qEmpty     (qEmpty),
    .qMode      (qHead[10:8]),
    .qSpeed     (qHead[7:0]),
    .lastByte   (lastByte),
    .lastXfer   (lastXfer),
    .csDrop     (csDrop),
    .waitOver   (waitOver),
    .txByte     (engTxByte),
    .engDone    (engDone),
    .engWcol    (engWcol),
    .engModf    (engModf),
    .st         (st),
    .popQ       (popQ),
    .inWait     (inWait),
    .engCfgLoad (engCfgLoad),
    .engMode    (engMode),
    .engSpeed   (engSpeed),
    .engTxValid (engTxValid),
    .csActive   (csActive),
    .msgDone    (msgDone),
    .msgErr     (msgErr),
    .spurious   (spurious)
  );

endmodule

// File: tb/test_spi_msg_seq.sv
module test_spi_msg_seq;
  localparam int CLK_PERIOD = 10;
  localparam int TICKS = 8;

  typedef struct {
    bit    err;
    int    act;
    string req;
  } exp_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic msgPush = 1'b0;
  logic [2:0] msgFirst = '0;
  logic [3:0] msgNum = '0;
  logic [2:0] msgMode = '0;
  logic [7:0] msgSpeed = '0;
  logic msgFull;
  logic xdWe = 1'b0;
  logic [2:0] xdAddr = '0;
  logic [6:0] xdLen = '0;
  logic xdTxEn = 1'b0, xdRxEn = 1'b0, xdCsDrop = 1'b0;
  logic [7:0] xdDelayUs = '0;
  logic [5:0] xdTxBase = '0, xdRxBase = '0;
  logic txWe = 1'b0;
  logic [5:0] txAddr = '0;
  logic [7:0] txData = '0;
  logic [5:0] rxAddr = '0;
  logic [7:0] rxData;
  logic engCfgLoad, engTxValid, csActive, msgDone, msgErr, spurious;
  logic [2:0] engMode;
  logic [7:0] engSpeed, engTxByte;
  logic [9:0] msgActualLen;
  logic mDone = 1'b0, mWcol = 1'b0, mModf = 1'b0, pokeDone = 1'b0;
  logic [7:0] mRx = '0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  spi_msg_seq i_spi_msg_seq (
    .clk(clk), .rstN(rstN),
    .msgPush(msgPush), .msgFirst(msgFirst), .msgNum(msgNum),
    .msgMode(msgMode), .msgSpeed(msgSpeed), .msgFull(msgFull),
    .xdWe(xdWe), .xdAddr(xdAddr), .xdLen(xdLen), .xdTxEn(xdTxEn),
    .xdRxEn(xdRxEn), .xdCsDrop(xdCsDrop), .xdDelayUs(xdDelayUs),
    .xdTxBase(xdTxBase), .xdRxBase(xdRxBase),
    .txWe(txWe), .txAddr(txAddr), .txData(txData),
    .rxAddr(rxAddr), .rxData(rxData),
    .engCfgLoad(engCfgLoad), .engMode(engMode), .engSpeed(engSpeed),
    .engTxValid(engTxValid), .engTxByte(engTxByte),
    .engDone(mDone | pokeDone), .engRxByte(mRx),
    .engWcol(mWcol), .engModf(mModf),
    .csActive(csActive), .msgDone(msgDone), .msgErr(msgErr),
    .msgActualLen(msgActualLen), .spurious(spurious)
  );

  int total = 0;
  int bad = 0;
  exp_t expQ[$];
  int doneCnt = 0, spurCnt = 0;
  bit fullSeen = 1'b0;

  // engine model state
  int cyc = 0, sendCnt = 0, pendIdx = 0, lat = 0;
  int wcolAt = -1, modfAt = -1;
  int csBad = 0, csFalls = 0, cfgCnt = 0;
  logic pend = 1'b0, csPrev = 1'b0;
  logic [7:0] pendByte = '0;
  logic [2:0] cfgMode = '0;
  logic [7:0] cfgSpeed = '0;
  logic [7:0] sentLog [64];
  int sendCyc [64];
  int doneCyc [64];

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // synchronous engine model: answers each request after a fixed latency
  always @(posedge clk) begin
    cyc   <= cyc + 1;
    mDone <= 1'b0;
    mWcol <= 1'b0;
    mModf <= 1'b0;
    if (engTxValid) begin
      sentLog[sendCnt] <= engTxByte;
      sendCyc[sendCnt] <= cyc;
      if (!csActive) csBad <= csBad + 1;
      pend     <= 1'b1;
      lat      <= 2;
      pendIdx  <= sendCnt;
      pendByte <= engTxByte;
      sendCnt  <= sendCnt + 1;
    end else if (pend) begin
      if (lat > 0) lat <= lat - 1;
      else begin
        pend <= 1'b0;
        doneCyc[pendIdx] <= cyc;
        if (pendIdx == wcolAt) mWcol <= 1'b1;
        else if (pendIdx == modfAt) mModf <= 1'b1;
        else begin
          mDone <= 1'b1;
          mRx   <= pendByte ^ 8'hA5;
        end
      end
    end
    if (engCfgLoad) begin
      cfgMode  <= engMode;
      cfgSpeed <= engSpeed;
      cfgCnt   <= cfgCnt + 1;
    end
    csPrev <= csActive;
    if (csPrev && !csActive) csFalls <= csFalls + 1;
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (rstN) begin
      if (msgFull) fullSeen = 1'b1;
      if (spurious) spurCnt++;
      if (msgDone) begin
        doneCnt++;
        if (expQ.size() == 0) begin
          check(1'b0, "R1", "unexpected completion", doneCnt, 0);
        end else begin
          exp_t e;
          e = expQ.pop_front();
          check(msgErr == e.err, e.req, "status", int'(msgErr), int'(e.err));
          check(int'(msgActualLen) == e.act, e.req, "actual length",
                int'(msgActualLen), e.act);
          check(!csActive, e.req, "chip select after completion", int'(csActive), 0);
        end
      end
    end
  end

  task automatic writeDesc(input int idx, input int len, input bit te, input bit re,
                           input bit drop, input int dly, input int tb, input int rb);
    @(negedge clk);
    xdWe = 1'b1; xdAddr = 3'(idx); xdLen = 7'(len); xdTxEn = te; xdRxEn = re;
    xdCsDrop = drop; xdDelayUs = 8'(dly); xdTxBase = 6'(tb); xdRxBase = 6'(rb);
    @(negedge clk);
    xdWe = 1'b0;
  endtask

  task automatic pushMsg(input int first, input int num, input int mode, input int spd,
                         input bit expErr, input int expAct, input string req);
    exp_t e;
    e.err = expErr; e.act = expAct; e.req = req;
    expQ.push_back(e);
    @(negedge clk);
    msgPush = 1'b1; msgFirst = 3'(first); msgNum = 4'(num);
    msgMode = 3'(mode); msgSpeed = 8'(spd);
    @(negedge clk);
    msgPush = 1'b0;
  endtask

  task automatic waitDone(input int n);
    while (doneCnt < n) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic checkRx(input int addr, input int exp, input string req);
    @(negedge clk);
    rxAddr = 6'(addr);
    #1;
    check(int'(rxData) == exp, req, "rx buffer byte", int'(rxData), exp);
  endtask

  task automatic summary;
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    summary();
    $finish;
  end

  initial begin
    int csF0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(!csActive && !engTxValid && !msgDone && !msgFull, "R1", "reset outputs",
          int'({csActive, engTxValid, msgDone, msgFull}), 0);
    rstN = 1'b1;

    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      txWe = 1'b1; txAddr = 6'(i); txData = 8'(i * 3 + 1);
    end
    @(negedge clk);
    txWe = 1'b0;

    writeDesc(0, 3, 1, 1, 0, 2, 0, 0);
    writeDesc(1, 2, 0, 1, 1, 0, 0, 8);
    writeDesc(2, 2, 1, 0, 0, 1, 10, 0);
    writeDesc(3, 4, 1, 1, 0, 0, 20, 20);

    // R10: engine event while idle
    @(negedge clk);
    pokeDone = 1'b1;
    @(negedge clk);
    pokeDone = 1'b0;
    repeat (2) @(negedge clk);
    check(spurCnt == 1, "R10", "spurious pulses", spurCnt, 1);
    check(!csActive && doneCnt == 0 && sendCnt == 0, "R10", "idle unaffected",
          int'(csActive) + doneCnt + sendCnt, 0);

    // message A: three transfers
    csF0 = csFalls;
    pushMsg(0, 3, 5, 8'h23, 1'b0, 7, "R9");
    waitDone(1);
    check(cfgCnt == 1 && cfgMode == 3'd5, "R2", "mode loaded", int'(cfgMode), 5);
    check(cfgSpeed == 8'h23, "R2", "speed loaded", int'(cfgSpeed), 8'h23);
    check(csBad == 0, "R2", "requests without chip select", csBad, 0);
    check(sendCnt == 7, "R3", "bytes sent", sendCnt, 7);
    check(sentLog[0] == 8'd1 && sentLog[1] == 8'd4 && sentLog[2] == 8'd7, "R3",
          "tx bytes from buffer", int'(sentLog[2]), 7);
    check(sentLog[3] == 8'h00 && sentLog[4] == 8'h00, "R3", "zero fill",
          int'(sentLog[3]) + int'(sentLog[4]), 0);
    check(sentLog[5] == 8'd31 && sentLog[6] == 8'd34, "R3", "second tx base",
          int'(sentLog[5]), 31);
    check(csFalls - csF0 == 2, "R8", "chip select releases", csFalls - csF0, 2);
    check(sendCyc[3] - doneCyc[2] >= 2 * TICKS && sendCyc[3] - doneCyc[2] <= 2 * TICKS + 6,
          "R7", "delay of 2 us", sendCyc[3] - doneCyc[2], 2 * TICKS + 4);
    check(sendCyc[5] - doneCyc[4] <= 6, "R7", "zero delay gap",
          sendCyc[5] - doneCyc[4], 4);
    checkRx(0, 1 ^ 8'hA5, "R4");
    checkRx(2, 7 ^ 8'hA5, "R4");
    checkRx(8, 8'hA5, "R4");
    checkRx(9, 8'hA5, "R4");

    // message B: collision on its second byte (send index 8)
    wcolAt = 8;
    pushMsg(3, 1, 2, 8'h10, 1'b0, 4, "R5");
    waitDone(2);
    check(sendCnt == 12, "R5", "bytes sent with retry", sendCnt, 12);
    check(sentLog[8] == 8'd64 && sentLog[9] == 8'd64, "R5", "same byte resent",
          int'(sentLog[9]), 64);
    check(sentLog[10] == 8'd67 && sentLog[11] == 8'd70, "R5", "sequence resumes",
          int'(sentLog[11]), 70);
    checkRx(21, 64 ^ 8'hA5, "R5");
    checkRx(23, 70 ^ 8'hA5, "R5");

    // message C: mode fault on the second byte of its second transfer
    modfAt = 15;
    pushMsg(1, 2, 0, 8'h01, 1'b1, 2, "R6");
    waitDone(3);
    repeat (6) @(negedge clk);
    check(sendCnt == 16, "R6", "no bytes after fault", sendCnt, 16);
    check(!csActive, "R6", "chip select after fault", int'(csActive), 0);
    // R4: transfer with receive off left address 0 unchanged
    checkRx(0, 1 ^ 8'hA5, "R4");

    // R1: six back-to-back pushes, queue of four, one popped immediately
    wcolAt = -1;
    modfAt = -1;
    for (int k = 0; k < 5; k++) begin
      exp_t e;
      e.err = 1'b0; e.act = 2; e.req = "R1";
      expQ.push_back(e);
    end
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      msgPush = 1'b1; msgFirst = 3'd2; msgNum = 4'd1; msgMode = 3'd0; msgSpeed = 8'd0;
    end
    @(negedge clk);
    msgPush = 1'b0;
    waitDone(8);
    repeat (60) @(negedge clk);
    check(fullSeen, "R1", "queue reported full", int'(fullSeen), 1);
    check(doneCnt == 8, "R1", "completions with one push dropped", doneCnt, 8);
    check(sendCnt == 26, "R1", "bytes for accepted messages", sendCnt, 26);
    check(expQ.size() == 0, "R1", "scoreboard drained", expQ.size(), 0);

    summary();
    $finish;
  end

endmodule